// File: doc/BRIEF.md
# PHY Trim Parameter Programming Sequencer

This block is a hardware sequencer that loads analog trim settings into a serial-link PHY. The PHY exposes its internal configuration registers only through an indirect test port: a 14-bit word driven into the PHY and an 8-bit value returned from it. The sequencer drives that word and samples the returned value. It has no direct register bus.

A single-cycle `start` request makes the sequencer walk a constant table of up to seven trim entries. Each entry names a PHY register, a bit field (upper and lower bit) and a field value. For each entry the sequencer reads the register and merges the new field into the value it read. It then writes the result back with a write-enable pulse and issues one more read of the same register, whose result it discards. Every change of the test word is held for two cycles so that the port can settle. A legacy-mode input, or an entry count of zero, finishes the request at once with no port activity. `done` pulses for one cycle when the work is complete.

Top module: `phy_trim_sequencer`

## Requirements
- R1: The test word places the write-enable flag in bit 0, the register address in bits 5:1 and the data byte in bits 13:6. Out of reset and whenever the sequencer is idle, the word is all zeros and `busy` and `done` are low.
- R2: A read presents the register address with data byte 1 and write-enable 0. The register contents are taken from `testOut` in the second cycle of that word.
- R3: Each new test word is held for exactly two clock cycles before the next one is presented.
- R4: A write presents the merged byte and address with write-enable 0, then the same word with write-enable 1, then the same word with write-enable 0 again, each for two cycles.
- R5: The written byte is the value just read, with bits lsb..msb replaced by (value << lsb) masked to that span; bits outside the span keep the value that was read.
- R6: Every write is followed directly by a read of the same register, whose result is not used.
- R7: Entries are processed in table order, and only the first `entryCount` entries are used. A count of 0 finishes with `done` on the next cycle and leaves the test word idle.
- R8: With `legacyMode` high, a start request produces `done` on the next cycle, no test-word activity and no register change.
- R9: A start request that arrives while `busy` is high has no effect on the running sequence or its length.
- R10: A run of N entries keeps `busy` high for exactly 10·N cycles. `done` is a single-cycle pulse in the first idle cycle after the run and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled while idle |
| legacyMode | input | 1 | Skip all table entries |
| entryCount | input | 3 | Number of table entries to program |
| testIn | output | 14 | Test word driven to the PHY: data[13:6], address[5:1], write-enable[0] |
| testOut | input | 8 | Value returned by the PHY test port |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the port discipline on every cycle. Each new word holds for two cycles, the write-enable pulse lasts exactly two cycles with a steady address and data, the enable stays low while idle, `done` and `busy` never coincide, a legacy request finishes in one cycle, and the entry index never passes the last selected entry. The bench scenarios cover what depends on data and order. They compare the full word trace against a model of the read, merge, write and dummy read for each entry, check the final contents of a register-file model of the PHY, and cover run lengths for different counts and starts that are ignored while busy.

// File: rtl/trimseq_pkg.sv
package trimseq_pkg;

  localparam int DataW      = 8;
  localparam int AddrW      = 5;
  localparam int MaxEntries = 7;
  localparam int CountW     = $clog2(MaxEntries + 1);
  localparam int IdxW       = (MaxEntries > 1) ? $clog2(MaxEntries) : 1;
  localparam int BitSelW    = $clog2(DataW);
  localparam int SettleCycles = 2;

  typedef struct packed {
    logic [DataW-1:0] data;
    logic [AddrW-1:0] addr;
    logic             we;
  } testWord_t;

  localparam int WordW = $bits(testWord_t);

  typedef struct packed {
    logic [AddrW-1:0]   regNo;
    logic [BitSelW-1:0] msb;
    logic [BitSelW-1:0] lsb;
    logic [DataW-1:0]   value;
  } trimEntry_t;

  // constant trim table, programmed in index order
  localparam trimEntry_t TrimTable [MaxEntries] = '{
    '{regNo: 5'd3,  msb: 3'd3, lsb: 3'd0, value: 8'h0A},
    '{regNo: 5'd5,  msb: 3'd7, lsb: 3'd4, value: 8'h03},
    '{regNo: 5'd6,  msb: 3'd2, lsb: 3'd1, value: 8'h02},
    '{regNo: 5'd10, msb: 3'd5, lsb: 3'd5, value: 8'h01},
    '{regNo: 5'd17, msb: 3'd7, lsb: 3'd0, value: 8'hC5},
    '{regNo: 5'd22, msb: 3'd6, lsb: 3'd2, value: 8'h13},
    '{regNo: 5'd31, msb: 3'd1, lsb: 3'd0, value: 8'h02}
  };

  typedef enum logic [2:0] {
    WK_IDLE, WK_READ, WK_WRLO, WK_WRHI, WK_WREND
  } wordKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            load;
    wordKind_e       kind;
    logic [IdxW-1:0] idx;
  } seqStrobe_t;

endpackage

// File: rtl/trimseq_ctrl.sv
module trimseq_ctrl
  import trimseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              legacyMode,
  input  logic [CountW-1:0] entryCount,
  output seqStrobe_t        strobe,
  output logic              busy,
  output logic              done
);

  typedef enum logic [2:0] {
    PH_IDLE, PH_READ, PH_WRLO, PH_WRHI, PH_WREND, PH_DUMMY
  } phase_e;

  localparam int SettleW = $clog2(SettleCycles);

  phase_e            phaseQ, phaseN;
  logic [SettleW-1:0] settleQ, settleN;
  logic [IdxW-1:0]   idxQ, idxN;
  logic [IdxW-1:0]   lastQ, lastN;
  logic              doneQ, doneN;
  logic [CountW-1:0] effCount;
  logic              settled;

  assign effCount = (entryCount > CountW'(MaxEntries)) ? CountW'(MaxEntries) : entryCount;
  assign settled  = (settleQ == SettleW'(SettleCycles - 1));

  always_comb begin
    phaseN = phaseQ;
    settleN = settleQ;
    idxN = idxQ;
    lastN = lastQ;
    doneN = 1'b0;
    strobe = '{load: 1'b0, kind: WK_IDLE, idx: idxQ};
    if (phaseQ == PH_IDLE) begin
      if (start) begin
        if (legacyMode || effCount == '0) begin
          doneN = 1'b1;
        end else begin
          phaseN = PH_READ;
          settleN = '0;
          idxN = '0;
          lastN = IdxW'(effCount - CountW'(1));
          strobe = '{load: 1'b1, kind: WK_READ, idx: '0};
        end
      end
    end else if (!settled) begin
      settleN = settleQ + SettleW'(1);
    end else begin
      settleN = '0;
      case (phaseQ)
        PH_READ: begin
          phaseN = PH_WRLO;
          strobe = '{load: 1'b1, kind: WK_WRLO, idx: idxQ};
        end
        PH_WRLO: begin
          phaseN = PH_WRHI;
          strobe = '{load: 1'b1, kind: WK_WRHI, idx: idxQ};
        end
        PH_WRHI: begin
          phaseN = PH_WREND;
          strobe = '{load: 1'b1, kind: WK_WREND, idx: idxQ};
        end
        PH_WREND: begin
          phaseN = PH_DUMMY;
          strobe = '{load: 1'b1, kind: WK_READ, idx: idxQ};
        end
        default: begin
          if (idxQ == lastQ) begin
            phaseN = PH_IDLE;
            doneN = 1'b1;
            strobe = '{load: 1'b1, kind: WK_IDLE, idx: idxQ};
          end else begin
            phaseN = PH_READ;
            idxN = idxQ + IdxW'(1);
            strobe = '{load: 1'b1, kind: WK_READ, idx: idxQ + IdxW'(1)};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      settleQ <= '0;
      idxQ <= '0;
      lastQ <= '0;
      doneQ <= 1'b0;
    end else begin
      phaseQ <= phaseN;
      settleQ <= settleN;
      idxQ <= idxN;
      lastQ <= lastN;
      doneQ <= doneN;
    end
  end

  assign busy = (phaseQ != PH_IDLE);
  assign done = doneQ;

  // R7: the walk never passes the last selected entry
  assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (idxQ <= lastQ));

  // R8: legacy request completes on the next cycle with no activity
  assert_legacy_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && legacyMode && !busy) |=> (done && !busy));

  // R10: done only in an idle cycle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/trimseq_dpath.sv
module trimseq_dpath
  import trimseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DataW-1:0] testOut,
  output logic [WordW-1:0] testIn
);

  testWord_t        wordQ;
  trimEntry_t       entry;
  logic [DataW-1:0] fieldMask;
  logic [DataW-1:0] fieldBits;
  logic [DataW-1:0] merged;

  assign entry = TrimTable[strobe.idx];

  always_comb begin
    for (int b = 0; b < DataW; b++) begin
      fieldMask[b] = (BitSelW'(b) >= entry.lsb) && (BitSelW'(b) <= entry.msb);
    end
  end

  assign fieldBits = (entry.value << entry.lsb) & fieldMask;
  assign merged    = (testOut & ~fieldMask) | fieldBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.load) begin
      case (strobe.kind)
        WK_READ:  wordQ <= '{data: DataW'(1), addr: entry.regNo, we: 1'b0};
        WK_WRLO:  wordQ <= '{data: merged, addr: entry.regNo, we: 1'b0};
        WK_WRHI:  wordQ <= '{data: wordQ.data, addr: wordQ.addr, we: 1'b1};
        WK_WREND: wordQ <= '{data: wordQ.data, addr: wordQ.addr, we: 1'b0};
        default:  wordQ <= '0;
      endcase
    end
  end

  assign testIn = wordQ;

  // R4: write-enable rises with data and address already in place
  assert_we_rise_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordQ.we) |-> ($stable(wordQ.data) && $stable(wordQ.addr)));

  // R4: write-enable stays high for a second cycle
  assert_we_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordQ.we) |=> wordQ.we);

  // R4: write-enable never lasts beyond two cycles
  assert_we_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wordQ.we && $past(wordQ.we)) |=> !wordQ.we);

endmodule

// File: rtl/phy_trim_sequencer.sv
module phy_trim_sequencer
  import trimseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              legacyMode,
  input  logic [CountW-1:0] entryCount,
  output logic [WordW-1:0]  testIn,
  input  logic [DataW-1:0]  testOut,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strobe;

  trimseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .legacyMode(legacyMode),
    .entryCount(entryCount), .strobe(strobe), .busy(busy), .done(done)
  );

  trimseq_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .testOut(testOut), .testIn(testIn)
  );

  // R3: a freshly presented word is held for its second settle cycle
  assert_word_settle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$stable(testIn)) |=> $stable(testIn));

  // R1: no write-enable while idle
  assert_idle_no_we_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !testIn[0]);

endmodule

// File: tb/sim_phy_trim_sequencer.sv
`timescale 1ns/1ps
module sim_phy_trim_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic legacyMode = 1'b0;
  logic [2:0] entryCount = '0;
  logic [13:0] testIn;
  logic [7:0] testOut;
  logic busy, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  phy_trim_sequencer u0 (
    .clk(clk), .rstN(rstN), .start(start), .legacyMode(legacyMode),
    .entryCount(entryCount), .testIn(testIn), .testOut(testOut),
    .busy(busy), .done(done)
  );

  // PHY register file model behind the test port
  logic [7:0] phyRegs [32];
  logic prevWe = 1'b0;
  assign testOut = phyRegs[testIn[5:1]];

  always @(posedge clk) begin
    if (testIn[0] && !prevWe) phyRegs[testIn[5:1]] <= testIn[13:6];
    prevWe <= testIn[0];
  end

  // word trace while busy, done pulse count
  logic [13:0] trace [80];
  int traceLen = 0;
  int doneSeen = 0;
  int doneWithBusy = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        if (traceLen < 80) trace[traceLen] = testIn;
        traceLen++;
      end
      if (done) doneSeen++;
      if (done && busy) doneWithBusy++;
    end
  end

  // bench copy of the trim table
  int tReg [7] = '{3, 5, 6, 10, 17, 22, 31};
  int tMsb [7] = '{3, 7, 2, 5, 7, 6, 1};
  int tLsb [7] = '{0, 4, 1, 5, 0, 2, 0};
  int tVal [7] = '{8'h0A, 8'h03, 8'h02, 8'h01, 8'hC5, 8'h13, 8'h02};

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic presetRegs(int seed, bit allOnes);
    for (int i = 0; i < 32; i++) phyRegs[i] = allOnes ? 8'hFF : 8'(i * 37 + seed);
  endtask

  // runs one request and checks trace, pulse and final register contents
  task automatic runSeq(int count, bit legacy, bit midStart, string req);
    logic [7:0]  expRegs [32];
    logic [13:0] expTrace [80];
    int expLen = 0;
    int n;
    for (int i = 0; i < 32; i++) expRegs[i] = phyRegs[i];
    if (!legacy) begin
      for (int e = 0; e < count; e++) begin
        logic [7:0] mask, merged;
        logic [13:0] rd, wlo, whi;
        mask = '0;
        for (int b = 0; b < 8; b++) if (b >= tLsb[e] && b <= tMsb[e]) mask[b] = 1'b1;
        merged = (expRegs[tReg[e]] & ~mask) | (8'(tVal[e] << tLsb[e]) & mask);
        expRegs[tReg[e]] = merged;
        rd  = {8'd1, 5'(tReg[e]), 1'b0};
        wlo = {merged, 5'(tReg[e]), 1'b0};
        whi = {merged, 5'(tReg[e]), 1'b1};
        for (int k = 0; k < 2; k++) begin expTrace[expLen] = rd;  expLen++; end
        for (int k = 0; k < 2; k++) begin expTrace[expLen] = wlo; expLen++; end
        for (int k = 0; k < 2; k++) begin expTrace[expLen] = whi; expLen++; end
        for (int k = 0; k < 2; k++) begin expTrace[expLen] = wlo; expLen++; end
        for (int k = 0; k < 2; k++) begin expTrace[expLen] = rd;  expLen++; end
      end
    end
    @(negedge clk);
    traceLen = 0;
    doneSeen = 0;
    doneWithBusy = 0;
    start = 1'b1;
    legacyMode = legacy;
    entryCount = 3'(count);
    @(negedge clk);
    start = 1'b0;
    entryCount = 3'd0;
    if (legacy || count == 0)
      check(done === 1'b1 && busy === 1'b0, req, "done on next cycle", {busy, done}, 2'b01);
    if (midStart) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      entryCount = 3'd7;
      @(negedge clk);
      start = 1'b0;
      entryCount = 3'd0;
    end
    n = 0;
    while (doneSeen == 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    legacyMode = 1'b0;
    check(traceLen == expLen, "R10", {req, " busy length"}, traceLen, expLen);
    check(doneSeen == 1, "R10", {req, " done pulse count"}, doneSeen, 1);
    check(doneWithBusy == 0, "R10", {req, " done with busy"}, doneWithBusy, 0);
    if (traceLen == expLen) begin
      for (int i = 0; i < expLen; i++)
        check(trace[i] == expTrace[i], (i % 10 < 2) ? "R2" : (i % 10 >= 8) ? "R6" : "R4",
              $sformatf("%s word %0d", req, i), trace[i], expTrace[i]);
    end
    for (int i = 0; i < 32; i++)
      check(phyRegs[i] == expRegs[i], "R5", $sformatf("%s reg %0d", req, i), phyRegs[i], expRegs[i]);
    check(testIn == 14'd0 && !busy, "R1", {req, " idle word"}, testIn, 0);
  endtask

  task automatic testReset();
    check(testIn == 14'd0, "R1", "reset testIn", testIn, 0);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    check(done == 1'b0, "R1", "reset done", done, 0);
  endtask

  task automatic testFullTable();
    presetRegs(8'h11, 1'b0);
    runSeq(7, 1'b0, 1'b0, "R3 R5 full table");
    presetRegs(0, 1'b1);
    runSeq(7, 1'b0, 1'b0, "R5 full table ones");
  endtask

  task automatic testSubsets();
    presetRegs(8'h42, 1'b0);
    runSeq(3, 1'b0, 1'b0, "R7 three entries");
    presetRegs(8'h05, 1'b0);
    runSeq(1, 1'b0, 1'b0, "R7 one entry");
    presetRegs(8'h63, 1'b0);
    runSeq(0, 1'b0, 1'b0, "R7 zero entries");
  endtask

  task automatic testLegacy();
    presetRegs(8'h29, 1'b0);
    runSeq(7, 1'b1, 1'b0, "R8 legacy");
  endtask

  task automatic testStartWhileBusy();
    presetRegs(8'h77, 1'b0);
    runSeq(2, 1'b0, 1'b1, "R9 start while busy");
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    presetRegs(0, 1'b0);
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFullTable();
    testSubsets();
    testLegacy();
    testStartWhileBusy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule